// File: doc/BRIEF.md
# Input Change Interrupt Merger

This block watches a wide vector of digital inputs, organised as a number of equal-width port groups, and raises one latched interrupt request when any bit of that vector takes a new value. Software does not have to poll the inputs. It arms the detector by setting a bit in the control register. It acknowledges an event by writing to a clear register. Until that clear write arrives, the request stays asserted however many more changes occur.

Each port group also gives one designated bit to a level-sensitive external interrupt source. A static strap input, one per group, allows that bit to drive the interrupt line. The strap-gated levels and the latched change flag are ORed into a single interrupt output. A status register shows the latched flag and the raw levels of the designated bits, with no strap gating.

All monitored inputs pass through a two-flop synchroniser before use. The register bus is a plain write strobe with a combinational read port. It is a control path, so it has no valid/ready handshake and never applies back-pressure.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, the latched change flag is 0, detection is disabled (control register bit 0 reads 0), the status register reads 0 and `irq` is 0.
- R2: With detection enabled, a change in any single bit or in several bits of `din` sets the change flag (status bit 0). The flag is set on the third rising edge after the input change, counted from the edge that first samples it.
- R3: With detection disabled, changes on `din` never set the change flag and never raise `irq`.
- R4: Once set, the change flag stays at 1 until a write to the clear register at address 1. A write to address 1 clears the flag, and writes to any other address leave it set.
- R5: If a clear write and a newly detected change fall on the same clock edge, the change wins and the flag stays at 1.
- R6: Enabling detection while the inputs are static does not set the change flag.
- R7: When strap `strap_en[g]` is 1, the synchronised level of bit `g*GROUP_W+EXT_BIT` (bit 19 and bit 43 by default) drives `irq` as a level. `irq` rises and falls with that level two edges later, and it does so regardless of whether detection is enabled.
- R8: When strap `strap_en[g]` is 0, the level of group g's designated bit has no effect on `irq`.
- R9: The status register at address 2 reads the change flag in bit 0 and the raw synchronised level of group g's designated bit in bit g+1, regardless of the straps. All other bits read 0.
- R10: `irq` equals the change flag ORed with every strap-enabled external level.
- R11: The control register at address 0 holds the detection enable in bit 0, and that bit reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | GROUP_W*NUM_GROUPS | Monitored input vector, asynchronous |
| strap_en | input | NUM_GROUPS | Static enables for the external level sources, one per group |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational from rd_addr |
| irq | output | 1 | Merged interrupt request |

## Verification
On every cycle, the embedded assertions check these rules:
- a set flag holds until a clear write arrives;
- a clear write with no competing change drops the flag;
- nothing sets the flag while detection is disabled;
- the flag always shows on `irq`;
- with no straps fitted, `irq` reflects only the flag.

The bench scenarios cover the remaining behaviour. They measure the latency from an input change to the flag, and they sweep a change across every single bit position. They also cover the race between a change and a clear write on the same edge, the absence of a false event when detection is armed, and an exhaustive sweep of strap and level combinations with the expected `irq` and status values computed from those combinations.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 8;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL   = 2'd0,
    RA_CLEAR  = 2'd1,
    RA_STATUS = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;
endmodule

// File: rtl/cos_detect.sv
module cos_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         det_en,
  input  logic [W-1:0] cur,
  input  logic         clr_wr,
  output logic         flag
);
  logic [W-1:0] prev_q;
  logic         flag_q;
  logic         hit;

  // The previous-sample register follows the current sample on every cycle.
  // Arming therefore compares against an up-to-date sample and cannot fire
  // a false event.
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  assign hit = det_en && (cur != prev_q);

  // A set takes priority over a clear on the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1;
    else if (clr_wr) flag_q <= 1'b0;
  end

  assign flag = flag_q;

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_wr) |=> flag_q); // R4
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !det_en) |=> !flag_q); // R4
  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en && !flag_q) |=> !flag_q); // R3
endmodule

// File: rtl/cos_regs.sv
module cos_regs
  import cos_pkg::*;
#(
  parameter int NUM_GROUPS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_AW-1:0]     wr_addr,
  input  logic [REG_DW-1:0]     wr_data,
  input  logic [REG_AW-1:0]     rd_addr,
  output logic [REG_DW-1:0]     rd_data,
  input  logic                  flag,
  input  logic [NUM_GROUPS-1:0] ext_lvl,
  output logic                  det_en,
  output logic                  clr_wr
);
  logic det_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                            det_en_q <= 1'b0;
    else if (wr_en && wr_addr == RA_CTRL)  det_en_q <= wr_data[0];
  end

  assign det_en = det_en_q;
  assign clr_wr = wr_en && (wr_addr == RA_CLEAR);

  always_comb begin
    rd_data = '0;
    if (rd_addr == RA_CTRL) begin
      rd_data[0] = det_en_q;
    end else if (rd_addr == RA_STATUS) begin
      rd_data[0]            = flag;
      rd_data[NUM_GROUPS:1] = ext_lvl;
    end
  end
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_pkg::*;
#(
  parameter int GROUP_W    = 24,
  parameter int NUM_GROUPS = 2,
  parameter int EXT_BIT    = 19
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [GROUP_W*NUM_GROUPS-1:0]   din,
  input  logic [NUM_GROUPS-1:0]           strap_en,
  input  logic                            wr_en,
  input  logic [REG_AW-1:0]               wr_addr,
  input  logic [REG_DW-1:0]               wr_data,
  input  logic [REG_AW-1:0]               rd_addr,
  output logic [REG_DW-1:0]               rd_data,
  output logic                            irq
);
  localparam int DATA_W = GROUP_W * NUM_GROUPS;

  logic [DATA_W-1:0]     cur;
  logic [NUM_GROUPS-1:0] ext_lvl;
  logic                  flag;
  logic                  det_en;
  logic                  clr_wr;

  cos_sync #(.W(DATA_W)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_async(din), .d_sync(cur)
  );

  // Tap the designated bit of each port group as an external level source.
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_ext
    assign ext_lvl[g] = cur[g*GROUP_W + EXT_BIT];
  end

  cos_detect #(.W(DATA_W)) det_i (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .cur(cur),
    .clr_wr(clr_wr), .flag(flag)
  );

  cos_regs #(.NUM_GROUPS(NUM_GROUPS)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .flag(flag), .ext_lvl(ext_lvl), .det_en(det_en), .clr_wr(clr_wr)
  );

  assign irq = flag | (|(ext_lvl & strap_en));

  AST_FLAG_DRIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> irq); // R10
  AST_STRAPLESS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && strap_en == '0) |-> !irq); // R8
endmodule

// File: tb/cos_irq_ctrl_tb_top.sv
module cos_irq_ctrl_tb_top;
  localparam int GW = 24;
  localparam int NG = 2;
  localparam int DW = GW * NG;
  localparam int EB = 19;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] din;
  logic [NG-1:0] strap;
  logic          wr_en;
  logic [1:0]    wr_addr;
  logic [7:0]    wr_data;
  logic [1:0]    rd_addr;
  logic [7:0]    rd_data;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cos_irq_ctrl #(.GROUP_W(GW), .NUM_GROUPS(NG), .EXT_BIT(EB)) dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .strap_en(strap),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    din = '0; strap = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; rst_n = 1'b0;
    ticks(3);
    rst_n = 1'b1;
    ticks(1);

    // R1: state after reset
    rd(2, v); chk("R1 status", v, 0);
    rd(0, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", irq, 0);

    // R3: changes while disabled
    din = 48'hA5A5_5A5A_0F0F;
    ticks(4);
    rd(2, v); chk("R3 flag idle-disabled", v[0], 0);

    // R6 and R11: arming on static inputs
    wr(0, 8'h01);
    ticks(4);
    rd(2, v); chk("R6 no false event", v[0], 0);
    rd(0, v); chk("R11 ctrl readback", v, 1);

    // R2: sweep a single-bit change across every position
    for (int i = 0; i < DW; i++) begin
      @(negedge clk);
      din[i] = ~din[i];
      ticks(2);
      rd(2, v); chk($sformatf("R2 not early bit %0d", i), v[0], 0);
      ticks(1);
      rd(2, v); chk($sformatf("R2 bit %0d", i), v[0], 1);
      chk($sformatf("R10 irq bit %0d", i), irq, 1);
      wr(1, 8'h00);
      ticks(1);
      rd(2, v); chk($sformatf("R4 cleared bit %0d", i), v[0], 0);
    end

    // R2: multi-bit change. R4: writes to other addresses keep the flag.
    @(negedge clk);
    din = ~din;
    ticks(3);
    rd(2, v); chk("R2 multi-bit", v[0], 1);
    wr(0, 8'h01);
    ticks(5);
    rd(2, v); chk("R4 hold after ctrl write", v[0], 1);
    wr(3, 8'hFF);
    rd(2, v); chk("R4 hold after addr3 write", v[0], 1);
    wr(2, 8'hFF);
    rd(2, v); chk("R4 hold after status write", v[0], 1);
    wr(1, 8'h00);
    ticks(1);
    rd(2, v); chk("R4 clear", v[0], 0);

    // R5: a change and a clear on the same edge
    @(negedge clk);
    din[5] = ~din[5];
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    rd(2, v); chk("R5 set wins", v[0], 1);
    wr(1, 8'h00);
    ticks(1);
    rd(2, v); chk("R5 later clear", v[0], 0);

    // R3: disabled detection ignores a burst of changes
    wr(0, 8'h00);
    rd(0, v); chk("R11 ctrl cleared", v, 0);
    for (int k = 0; k < 8; k++) begin
      din = din ^ (48'h1 << (k * 6));
      ticks(1);
    end
    ticks(4);
    rd(2, v); chk("R3 flag disabled", v[0], 0);
    chk("R3 irq disabled", irq, 0);
    wr(0, 8'h01);
    ticks(4);
    rd(2, v); chk("R6 re-arm", v[0], 0);
    wr(0, 8'h00);

    // R7, R8 and R9: exhaustive sweep over strap and level combinations
    din[EB] = 1'b0; din[GW + EB] = 1'b0;
    ticks(3);
    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 4; l++) begin
        @(negedge clk);
        strap = s[1:0];
        din[EB] = l[0];
        din[GW + EB] = l[1];
        ticks(3);
        if ((s & l) != 0)
          chk($sformatf("R7 irq s=%0d l=%0d", s, l), irq, 1);
        else
          chk($sformatf("R8 irq s=%0d l=%0d", s, l), irq, 0);
        rd(2, v); chk($sformatf("R9 status s=%0d l=%0d", s, l), v, l << 1);
      end
    end

    // R7: level behaviour, held and then released
    @(negedge clk);
    strap = 2'b11; din[EB] = 1'b1; din[GW + EB] = 1'b0;
    ticks(3);
    chk("R7 level high", irq, 1);
    ticks(10);
    chk("R7 level held", irq, 1);
    din[EB] = 1'b0;
    ticks(1);
    chk("R7 release latency", irq, 1);
    ticks(2);
    chk("R7 level low", irq, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule